// File: doc/BRIEF.md
# Multi-Slot In-Order Retire Queue

This block keeps in-flight instructions in program order inside a circular array of slots. An instruction asks for room by giving its micro-op count. It is granted that many consecutive slots, with the count capped at the array size and raised to one for a zero count. It then receives a token, which is the index of its first slot. One array position therefore stands for a whole instruction, and the head and tail pointers move by whole entries rather than by single slots.

A completion port marks an instruction as finished using its token. Each cycle the retire logic starts at the head and releases the oldest entries in order. It stops at the first one that has not finished, or when a parameter cap is reached. A cap of zero removes the limit. The retire output reports the token of each released entry on its own lane, oldest in lane 0. The free-slot counter gets back every slot those entries held.

An allocation is accepted on a clock edge where the request valid and ready are both high. The token is valid in the same cycle as the request. A completion takes effect at the edge where it is presented, so the earliest an entry can retire is the following cycle.

Top module: `rq_retire_queue`

## Requirements
- R1: The slot count of a request is its micro-op count, limited to DEPTH; a count of zero takes exactly one slot. When all DEPTH slots are free, every request is accepted.
- R2: `alloc_token_o` equals the current tail slot index. After an accepted request the tail moves forward by the slot count modulo DEPTH; otherwise it holds.
- R3: `alloc_ready_o` is high exactly when `free_slots_o` is at least the slot count of the current request.
- R4: A completion with a token marks that entry finished at the clock edge where it is presented. The entry can appear on the retire output from the next cycle on.
- R5: Retirement is strictly in order. While the head entry is unfinished, nothing retires, even if younger entries are finished.
- R6: `ret_valid_o` lanes are contiguous from lane 0. Lane k carries the starting slot index of the k-th oldest entry, in bits [k*IDX_W +: IDX_W] of `ret_token_o`. At most MAX_RETIRE lanes are set per cycle, and none are set when the queue is empty.
- R7: With MAX_RETIRE = 0 the retire output has DEPTH lanes. Every finished entry in an unbroken run at the head retires in one cycle.
- R8: After reset `free_slots_o` equals DEPTH, the token is 0 and no lane is valid. Each edge adds back the slots of retired entries and removes the slots of an accepted request, so `free_slots_o` never exceeds DEPTH.
- R9: Slot indices, tokens and the head and tail pointers wrap modulo DEPTH. An entry may span the end of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_uops_i | input | UOP_W | Micro-op count of the request |
| alloc_ready_o | output | 1 | Enough free slots for the request |
| alloc_token_o | output | IDX_W | Token (starting slot) for the request |
| done_valid_i | input | 1 | Execution-complete event |
| done_token_i | input | IDX_W | Token of the finished entry |
| ret_valid_o | output | LANES | Per-lane retire strobe, lane 0 oldest |
| ret_token_o | output | LANES*IDX_W | Tokens of retiring entries, packed by lane |
| free_slots_o | output | CNT_W | Number of unreserved slots |

## Verification
Several properties are checked on every cycle: the free count stays within bounds, the tail moves by the normalized slot count and holds otherwise, an empty queue retires nothing, a fully free queue accepts any request, and retire lanes stay contiguous. The in-order blocking by an unfinished head, the one-cycle delay from completion to retirement, the retire cap against the unlimited setting, and exact token values across wrap-around need a history of allocations and completions. Only the bench's directed and random scenarios show these, by comparing each cycle with a behavioural model of the entry list.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic {
        EXEC_PENDING = 1'b0,
        EXEC_DONE    = 1'b1
    } exec_state_e;

    // Number of retire lanes: a cap of zero (or above the depth) means one lane per slot.
    function automatic int rq_lane_count(input int depth, input int max_ret);
        if (max_ret <= 0 || max_ret > depth) return depth;
        return max_ret;
    endfunction

endpackage

// File: rtl/rq_alloc_norm.sv
module rq_alloc_norm #(
    parameter int DEPTH = 16,
    parameter int UOP_W = 5,
    parameter int CNT_W = 5
) (
    input  logic [UOP_W-1:0] uops_i,
    input  logic [CNT_W-1:0] free_i,
    output logic [CNT_W-1:0] slots_o,
    output logic             fits_o
);
    localparam int WW = ((UOP_W > CNT_W) ? UOP_W : CNT_W) + 1;

    logic [WW-1:0] req_w;
    logic [WW-1:0] lim_w;
    logic [WW-1:0] n_w;

    always_comb begin
        req_w = WW'(uops_i);
        lim_w = WW'(DEPTH);
        if (req_w == '0) begin
            n_w = WW'(1);
        end else if (req_w > lim_w) begin
            n_w = lim_w;
        end else begin
            n_w = req_w;
        end
        slots_o = CNT_W'(n_w);
        fits_o  = (WW'(free_i) >= n_w);
    end

endmodule

// File: rtl/rq_retire_scan.sv
module rq_retire_scan
    import rq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LANES = 2,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic [IDX_W-1:0] head_i,
    input  logic [CNT_W-1:0] used_i,
    input  logic             live_i  [DEPTH],
    input  exec_state_e      exec_i  [DEPTH],
    input  logic [CNT_W-1:0] nslot_i [DEPTH],
    output logic [LANES-1:0] take_o,
    output logic [IDX_W-1:0] ptr_o   [LANES],
    output logic [CNT_W-1:0] freed_o
);
    localparam int SW = CNT_W + 1;

    // off[k]: slots covered by the k oldest entries that retire this cycle
    logic [SW-1:0] off [LANES+1];
    logic          go  [LANES+1];

    assign off[0] = '0;
    assign go[0]  = 1'b1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SW-1:0]    raw;
        logic [IDX_W-1:0] pos;
        logic             hit;

        assign raw = SW'(head_i) + off[k];
        assign pos = (raw >= SW'(DEPTH)) ? IDX_W'(raw - SW'(DEPTH)) : IDX_W'(raw);
        assign hit = go[k] && (off[k] < SW'(used_i)) && live_i[pos]
                     && (exec_i[pos] == EXEC_DONE);

        assign go[k+1]  = hit;
        assign off[k+1] = hit ? (off[k] + SW'(nslot_i[pos])) : off[k];
        assign take_o[k] = hit;
        assign ptr_o[k]  = pos;
    end

    assign freed_o = CNT_W'(off[LANES]);

endmodule

// File: rtl/rq_retire_queue.sv
module rq_retire_queue
    import rq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int MAX_RETIRE = 2,
    parameter int UOP_W      = 5,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int LANES     = rq_lane_count(DEPTH, MAX_RETIRE)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid_i,
    input  logic [UOP_W-1:0]       alloc_uops_i,
    output logic                   alloc_ready_o,
    output logic [IDX_W-1:0]       alloc_token_o,
    input  logic                   done_valid_i,
    input  logic [IDX_W-1:0]       done_token_i,
    output logic [LANES-1:0]       ret_valid_o,
    output logic [LANES*IDX_W-1:0] ret_token_o,
    output logic [CNT_W-1:0]       free_slots_o
);
    localparam int SW = CNT_W + 1;

    // Pointer and occupancy state
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;
    logic [CNT_W-1:0] free_q;

    // Per-slot entry metadata (meaningful only at an entry's first slot)
    logic             live_q  [DEPTH];
    exec_state_e      exec_q  [DEPTH];
    logic [CNT_W-1:0] nslot_q [DEPTH];

    logic [CNT_W-1:0] req_n;
    logic             fits;
    logic             fire;
    logic [CNT_W-1:0] used;
    logic [CNT_W-1:0] freed;
    logic [LANES-1:0] lane_take;
    logic [IDX_W-1:0] lane_ptr [LANES];
    logic [DEPTH-1:0] slot_clr;

    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] p,
                                                  input logic [CNT_W-1:0] n);
        logic [SW-1:0] s;
        s = SW'(p) + SW'(n);
        if (s >= SW'(DEPTH)) s = s - SW'(DEPTH);
        return IDX_W'(s);
    endfunction

    rq_alloc_norm #(
        .DEPTH (DEPTH),
        .UOP_W (UOP_W),
        .CNT_W (CNT_W)
    ) u_norm (
        .uops_i  (alloc_uops_i),
        .free_i  (free_q),
        .slots_o (req_n),
        .fits_o  (fits)
    );

    assign used = CNT_W'(DEPTH) - free_q;

    rq_retire_scan #(
        .DEPTH (DEPTH),
        .LANES (LANES),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_scan (
        .head_i  (head_q),
        .used_i  (used),
        .live_i  (live_q),
        .exec_i  (exec_q),
        .nslot_i (nslot_q),
        .take_o  (lane_take),
        .ptr_o   (lane_ptr),
        .freed_o (freed)
    );

    assign fire = alloc_valid_i && fits;

    always_comb begin
        slot_clr = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_take[k]) slot_clr[lane_ptr[k]] = 1'b1;
        end
    end

    // Pointer and free-count register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            free_q <= CNT_W'(DEPTH);
        end else begin
            head_q <= wrap_add(head_q, freed);
            if (fire) tail_q <= wrap_add(tail_q, req_n);
            free_q <= free_q + freed - (fire ? req_n : '0);
        end
    end

    // Slot metadata register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                live_q[s]  <= 1'b0;
                exec_q[s]  <= EXEC_PENDING;
                nslot_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (slot_clr[s]) live_q[s] <= 1'b0;
                if (fire && (tail_q == IDX_W'(s))) begin
                    live_q[s]  <= 1'b1;
                    exec_q[s]  <= EXEC_PENDING;
                    nslot_q[s] <= req_n;
                end else if (done_valid_i && (done_token_i == IDX_W'(s))) begin
                    exec_q[s] <= EXEC_DONE;
                end
            end
        end
    end

    // Output process
    assign alloc_ready_o = fits;
    assign alloc_token_o = tail_q;
    assign free_slots_o  = free_q;
    assign ret_valid_o   = lane_take;
    for (genvar k = 0; k < LANES; k++) begin : g_tok
        assign ret_token_o[k*IDX_W +: IDX_W] = lane_ptr[k];
    end

endmodule

// File: rtl/rq_retire_queue_chk.sv
module rq_retire_queue_chk
    import rq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int MAX_RETIRE = 2,
    parameter int UOP_W      = 5,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int LANES     = rq_lane_count(DEPTH, MAX_RETIRE)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid_i,
    input logic [UOP_W-1:0] alloc_uops_i,
    input logic             alloc_ready_o,
    input logic [IDX_W-1:0] alloc_token_o,
    input logic [LANES-1:0] ret_valid_o,
    input logic [CNT_W-1:0] free_slots_o
);
    function automatic int norm_slots(input int u);
        if (u == 0) return 1;
        if (u > DEPTH) return DEPTH;
        return u;
    endfunction

    // R8: free count bounded by the array size
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots_o <= CNT_W'(DEPTH));

    // R8: a retirement without an allocation raises the free count
    p_retire_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_o[0] && !(alloc_valid_i && alloc_ready_o))
        |=> (free_slots_o > $past(free_slots_o)));

    // R6: an empty queue retires nothing
    p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slots_o == CNT_W'(DEPTH)) |-> (ret_valid_o == '0));

    // R1: with every slot free any request fits
    p_full_free_accepts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slots_o == CNT_W'(DEPTH)) |-> alloc_ready_o);

    // R2: tail steps by the normalized slot count
    p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && alloc_ready_o)
        |=> (int'(alloc_token_o) ==
             (($past(int'(alloc_token_o)) + norm_slots(int'($past(alloc_uops_i)))) % DEPTH)));

    // R2: tail holds without an accepted request
    p_tail_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_valid_i && alloc_ready_o) |=> $stable(alloc_token_o));

    // R6: retire lanes fill from lane 0 without gaps
    for (genvar k = 1; k < LANES; k++) begin : g_contig
        p_lane_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid_o[k] |-> ret_valid_o[k-1]);
    end

endmodule

bind rq_retire_queue rq_retire_queue_chk #(
    .DEPTH      (DEPTH),
    .MAX_RETIRE (MAX_RETIRE),
    .UOP_W      (UOP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid_i (alloc_valid_i),
    .alloc_uops_i  (alloc_uops_i),
    .alloc_ready_o (alloc_ready_o),
    .alloc_token_o (alloc_token_o),
    .ret_valid_o   (ret_valid_o),
    .free_slots_o  (free_slots_o)
);

// File: tb/rq_retire_queue_test.sv
`timescale 1ns/1ps
module rq_retire_queue_test;
    import rq_pkg::*;

    localparam int D  = 16;
    localparam int UW = 5;
    localparam int IW = 4;
    localparam int CW = 5;
    localparam int L0 = rq_lane_count(D, 2);
    localparam int L1 = rq_lane_count(D, 0);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [UW-1:0] alloc_uops = '0;
    logic dv0 = 1'b0, dv1 = 1'b0;
    logic [IW-1:0] dt0 = '0, dt1 = '0;

    logic rdy0, rdy1;
    logic [IW-1:0] tok0, tok1;
    logic [L0-1:0] rv0;
    logic [L0*IW-1:0] rt0;
    logic [L1-1:0] rv1;
    logic [L1*IW-1:0] rt1;
    logic [CW-1:0] fr0, fr1;

    always #4 clk = ~clk;

    rq_retire_queue #(.DEPTH(D), .MAX_RETIRE(2), .UOP_W(UW)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid), .alloc_uops_i(alloc_uops),
        .alloc_ready_o(rdy0), .alloc_token_o(tok0),
        .done_valid_i(dv0), .done_token_i(dt0),
        .ret_valid_o(rv0), .ret_token_o(rt0), .free_slots_o(fr0));

    rq_retire_queue #(.DEPTH(D), .MAX_RETIRE(0), .UOP_W(UW)) uut_wide (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid), .alloc_uops_i(alloc_uops),
        .alloc_ready_o(rdy1), .alloc_token_o(tok1),
        .done_valid_i(dv1), .done_token_i(dt1),
        .ret_valid_o(rv1), .ret_token_o(rt1), .free_slots_o(fr1));

    // Behavioural model: per instance, a circular list of entries in program order
    int m_tok [2][D];
    int m_n   [2][D];
    int m_ex  [2][D];
    int m_hd  [2];
    int m_cnt [2];
    int m_tail[2];
    int m_free[2];
    int d_idx [2];

    int errors = 0;
    int checks = 0;
    string phase = "";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    function automatic int norm(input int u);
        if (u == 0) return 1;
        if (u > D) return D;
        return u;
    endfunction

    task automatic evaluate(input int i, input bit av, input int u);
        int lim, lanes, r, n, idx, act_rdy, act_tok, act_fr, lv, lt;
        bit exp_rdy;
        lim   = (i == 0) ? 2 : 0;
        lanes = (i == 0) ? L0 : L1;
        n     = norm(u);
        act_rdy = (i == 0) ? int'(rdy0) : int'(rdy1);
        act_tok = (i == 0) ? int'(tok0) : int'(tok1);
        act_fr  = (i == 0) ? int'(fr0)  : int'(fr1);
        exp_rdy = (m_free[i] >= n);
        r = 0;
        while (r < m_cnt[i] && m_ex[i][(m_hd[i] + r) % D] != 0 && (lim == 0 || r < lim)) r++;
        chk(act_rdy == int'(exp_rdy), "R3 ready", act_rdy, int'(exp_rdy));
        chk(act_tok == m_tail[i], "R2 token", act_tok, m_tail[i]);
        chk(act_fr == m_free[i], "R8 free count", act_fr, m_free[i]);
        for (int k = 0; k < lanes; k++) begin
            lv = (i == 0) ? int'(rv0[k]) : int'(rv1[k]);
            lt = (i == 0) ? int'(rt0[k*IW +: IW]) : int'(rt1[k*IW +: IW]);
            chk(lv == int'(k < r), "R6 lane valid", lv, int'(k < r));
            if (k < r) chk(lt == m_tok[i][(m_hd[i] + k) % D], "R6 lane token", lt,
                           m_tok[i][(m_hd[i] + k) % D]);
        end
        // state update for the coming edge
        for (int j = 0; j < r; j++) begin
            m_free[i] += m_n[i][m_hd[i]];
            m_hd[i] = (m_hd[i] + 1) % D;
            m_cnt[i]--;
        end
        if (d_idx[i] >= 0) m_ex[i][d_idx[i]] = 1;
        if (av && exp_rdy) begin
            idx = (m_hd[i] + m_cnt[i]) % D;
            m_tok[i][idx] = m_tail[i];
            m_n[i][idx]   = n;
            m_ex[i][idx]  = 0;
            m_cnt[i]++;
            m_tail[i] = (m_tail[i] + n) % D;
            m_free[i] -= n;
        end
    endtask

    // One cycle: av/u drive allocation, p0/p1 pick the list position to complete (-1: none)
    task automatic step(input bit av, input int u, input int p0, input int p1);
        int p, idx;
        @(negedge clk);
        alloc_valid = av;
        alloc_uops  = UW'(u);
        for (int i = 0; i < 2; i++) begin
            p = (i == 0) ? p0 : p1;
            d_idx[i] = -1;
            if (p >= 0 && p < m_cnt[i]) begin
                idx = (m_hd[i] + p) % D;
                if (m_ex[i][idx] == 0) d_idx[i] = idx;
            end
        end
        dv0 = (d_idx[0] >= 0);
        dt0 = IW'((d_idx[0] >= 0) ? m_tok[0][d_idx[0]] : 0);
        dv1 = (d_idx[1] >= 0);
        dt1 = IW'((d_idx[1] >= 0) ? m_tok[1][d_idx[1]] : 0);
        #1;
        evaluate(0, av, u);
        evaluate(1, av, u);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired [%s] actual=0 expected=1", phase);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_hd[i] = 0; m_cnt[i] = 0; m_tail[i] = 0; m_free[i] = D; d_idx[i] = -1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R8 reset state";
        #1;
        chk(rv0 == '0 && rv1 == '0, "R8 no retire after reset", int'(rv0), 0);
        chk(fr0 == CW'(D), "R8 free after reset", int'(fr0), D);
        step(0, 0, -1, -1);

        phase = "R1 zero and oversize counts";
        step(1, 0, -1, -1);      // one slot, token 0
        step(1, 20, -1, -1);     // needs 16, only 15 free: refused
        step(0, 0, 0, 0);
        step(0, 0, -1, -1);      // retires
        step(1, 20, -1, -1);     // clamped to 16, fills the array
        step(1, 1, -1, -1);      // refused, nothing free
        step(0, 0, 0, 0);
        step(0, 0, -1, -1);
        step(0, 0, -1, -1);

        phase = "R4 R5 in-order blocking";
        step(1, 3, -1, -1);
        step(1, 2, -1, -1);
        step(1, 1, -1, -1);
        step(0, 0, 2, 2);        // youngest finishes
        step(0, 0, 1, 1);
        step(0, 0, -1, -1);      // head still pending: no retire
        step(0, 0, -1, -1);
        step(0, 0, 0, 0);        // head finishes, retires next cycle
        repeat (3) step(0, 0, -1, -1);

        phase = "R7 unlimited retire width";
        repeat (5) step(1, 1, -1, -1);
        for (int p = 4; p >= 0; p--) step(0, 0, p, p);
        repeat (4) step(0, 0, -1, -1);

        phase = "R9 random traffic with wrap";
        for (int c = 0; c < 3000; c++) begin
            bit av;
            int u, p0, p1;
            av = ($urandom % 10) < 6;
            u  = (($urandom % 8) == 0) ? int'($urandom_range(9, 31)) : int'($urandom_range(0, 4));
            p0 = (($urandom % 3) == 0) ? -1 : int'($urandom_range(0, 5));
            p1 = (($urandom % 3) == 0) ? -1 : int'($urandom_range(0, 5));
            step(av, u, p0, p1);
        end
        for (int c = 0; c < 40; c++) step(0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule